// File: doc/BRIEF.md
# Clock Source Mode Controller

This block decides which oscillator feeds the CPU clock and keeps track of the low-power state around it. It has three clock statuses. In status 1 the CPU runs from the internal oscillator and the high-speed oscillator is off. In status 2 the CPU still runs from the internal oscillator, but the high-speed oscillator is running. In status 3 the CPU runs from the high-speed oscillator. Software moves between the statuses by writing two control fields: an oscillator-stop field and a clock-select field. The block refuses any move that would be unsafe, leaves the status as it was, and records the refusal in a sticky error flag.

Oscillators are modelled as enables. A stabilization counter runs whenever the high-speed oscillator is on. It gates the switch to that oscillator unless an RC-clock option removes the wait. HALT and STOP requests park the CPU, and an interrupt resumes it in the status it left. A watchdog counts on the internal oscillator, which may keep running through STOP by option. If the watchdog overflows, it resets the block together with the other reset sources.

Top module: `clk_mode_ctrl`

## Requirements
- R1: Reset (`rst_ni` low, or `por_i`, `lvd_i` or `clkmon_i` high at a clock edge) leaves the block in status 1 (`status_o`=1), run mode, with `hs_run_o`, `mcs_o`, `stab_done_o` and `err_o` all 0.
- R2: In status 1, a write (`reg_wr_i`) with stop=0 and sel=0 moves the block to status 2 at the next edge and turns `hs_run_o` on.
- R3: `stab_done_o` rises exactly 2^E clock edges after the edge at which `hs_run_o` turns on, where E = 11 + `stab_sel_i`, and any `stab_sel_i` above 5 gives E = 16. The flag clears at the edge after `hs_run_o` is 0.
- R4: In status 2, a write with sel=1 and stop=0 moves the block to status 3 (`mcs_o`=1) only if `stab_done_o` or `opt_rc_i` is 1. Otherwise the status is unchanged and `err_o` is set. A write with sel=1 is also refused in status 1.
- R5: In status 2, a write with stop=1 and sel=0 moves the block to status 1 and stops the high-speed oscillator. Any write with stop=1 while in status 3 is refused, as is a write with stop=1 and sel=1 in status 2. A refused write leaves the status unchanged and sets `err_o`.
- R6: In status 3, a write with stop=0 and sel=0 returns the block to status 2.
- R7: In run mode, `halt_req_i` enters HALT: `halt_o`=1 and `cpu_clk_en_o`=0, with the status and oscillators unchanged. `irq_i` returns the block to run in the same status.
- R8: In run mode, `stop_req_i` enters STOP. `stop_o`=1 and `hs_run_o`=0, and `int_run_o` is 0 unless `opt_keep_i`=1. If both STOP and HALT are requested together, STOP wins. `irq_i` releases STOP into the same status. In status 3, `cpu_clk_en_o` stays 0 until `stab_done_o` (or `opt_rc_i`) is 1.
- R9: The watchdog advances on each edge while `int_run_o` is 1 and is cleared by `wdt_clr_i`. It is frozen while `int_run_o` is 0. After 2^WDT_W counts without a clear, `wdt_rst_o` pulses for one cycle and the block is reset as in R1.
- R10: `err_o` stays set until a reset. Writes made in HALT or STOP have no effect on status or `err_o`.
- R11: If a watchdog overflow falls in the same cycle as an interrupt that releases STOP, the reset wins: the block ends in status 1, run mode, with `wdt_rst_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low external reset |
| por_i | input | 1 | Power-on clear reset request |
| lvd_i | input | 1 | Low-voltage detect reset request |
| clkmon_i | input | 1 | Clock monitor reset request |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_stop_i | input | 1 | Written value of the oscillator-stop field |
| reg_sel_i | input | 1 | Written value of the clock-select field |
| halt_req_i | input | 1 | HALT request |
| stop_req_i | input | 1 | STOP request |
| irq_i | input | 1 | Interrupt, releases HALT/STOP |
| opt_rc_i | input | 1 | Option: high-speed clock is RC, no stabilization wait |
| opt_keep_i | input | 1 | Option: internal oscillator never stops |
| stab_sel_i | input | STAB_SEL_W (3) | Stabilization exponent select |
| wdt_clr_i | input | 1 | Watchdog clear |
| status_o | output | 2 | Clock status 1, 2 or 3 |
| mcs_o | output | 1 | CPU clock source flag, 1 = high-speed |
| hs_run_o | output | 1 | High-speed oscillator enabled |
| int_run_o | output | 1 | Internal oscillator enabled |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| halt_o | output | 1 | In HALT |
| stop_o | output | 1 | In STOP |
| stab_done_o | output | 1 | Stabilization complete |
| err_o | output | 1 | Sticky refused-write flag |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
Two events can land in the same cycle: a watchdog overflow, and the interrupt that ends STOP when the internal oscillator is kept alive. The bench provokes this collision by following its own model's watchdog count. It raises `irq_i` in exactly the cycle the count sits at its maximum. It then judges the next cycle: the block must be in status 1 and in run mode, with the reset pulse high, and must not have resumed its pre-STOP status.

// File: rtl/ckm_pkg.sv
`timescale 1ns/1ps
package ckm_pkg;
  typedef enum logic [1:0] {
    ST_1 = 2'd1,
    ST_2 = 2'd2,
    ST_3 = 2'd3
  } ck_stat_e;

  typedef enum logic [1:0] {
    PW_RUN  = 2'd0,
    PW_HALT = 2'd1,
    PW_STOP = 2'd2
  } pwr_e;
endpackage

// File: rtl/ckm_stab_cnt.sv
`timescale 1ns/1ps
module ckm_stab_cnt #(
  parameter int MIN_EXP = 11,
  parameter int MAX_EXP = 16,
  parameter int SEL_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             done_o
);
  localparam int CNT_W = MAX_EXP + 1;
  localparam int SPAN  = MAX_EXP - MIN_EXP;

  logic [CNT_W-1:0] cnt_q, cnt_nx, limit;
  logic             done_q;
  int unsigned      expo;

  always_comb begin
    expo   = (int'(sel_i) > SPAN) ? MAX_EXP : (MIN_EXP + int'(sel_i));
    limit  = CNT_W'(1) << expo;
    cnt_nx = cnt_q + 1'b1;
  end

  // restart implied: oscillator off clears the count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clr_i || !run_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q <= cnt_nx;
      if (cnt_nx >= limit) done_q <= 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/ckm_wdt.sv
`timescale 1ns/1ps
module ckm_wdt #(
  parameter int W = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic kick_i,
  input  logic run_i,
  output logic ovf_o
);
  logic [W-1:0] cnt_q;

  assign ovf_o = run_i && !kick_i && (cnt_q == {W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || kick_i)  cnt_q <= '0;
    else if (run_i)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ckm_mode_fsm.sv
`timescale 1ns/1ps
module ckm_mode_fsm
  import ckm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     soft_rst_i,
  input  logic     wr_i,
  input  logic     wr_stop_i,
  input  logic     wr_sel_i,
  input  logic     halt_req_i,
  input  logic     stop_req_i,
  input  logic     irq_i,
  input  logic     stab_ok_i,
  output ck_stat_e st_o,
  output pwr_e     pwr_o,
  output logic     err_o
);
  ck_stat_e st_q, st_d;
  pwr_e     pwr_q, pwr_d;
  logic     err_q, err_d;

  always_comb begin
    st_d  = st_q;
    pwr_d = pwr_q;
    err_d = err_q;
    case (pwr_q)
      PW_RUN: begin
        if (wr_i) begin
          case (st_q)
            ST_1: begin
              if (wr_sel_i)        err_d = 1'b1;
              else if (!wr_stop_i) st_d  = ST_2;
            end
            ST_2: begin
              if (wr_sel_i) begin
                if (wr_stop_i || !stab_ok_i) err_d = 1'b1;
                else                         st_d  = ST_3;
              end else if (wr_stop_i) begin
                st_d = ST_1;
              end
            end
            ST_3: begin
              if (wr_stop_i)      err_d = 1'b1;
              else if (!wr_sel_i) st_d  = ST_2;
            end
            default: st_d = ST_1;
          endcase
        end
        if (stop_req_i)      pwr_d = PW_STOP;
        else if (halt_req_i) pwr_d = PW_HALT;
      end
      PW_HALT, PW_STOP: if (irq_i) pwr_d = PW_RUN;
      default: pwr_d = PW_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_1;
      pwr_q <= PW_RUN;
      err_q <= 1'b0;
    end else if (soft_rst_i) begin
      st_q  <= ST_1;
      pwr_q <= PW_RUN;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pwr_q <= pwr_d;
      err_q <= err_d;
    end
  end

  assign st_o  = st_q;
  assign pwr_o = pwr_q;
  assign err_o = err_q;
endmodule

// File: rtl/clk_mode_ctrl.sv
`timescale 1ns/1ps
module clk_mode_ctrl
  import ckm_pkg::*;
#(
  parameter int STAB_MIN_EXP = 11,
  parameter int STAB_MAX_EXP = 16,
  parameter int STAB_SEL_W   = 3,
  parameter int WDT_W        = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  por_i,
  input  logic                  lvd_i,
  input  logic                  clkmon_i,
  input  logic                  reg_wr_i,
  input  logic                  reg_stop_i,
  input  logic                  reg_sel_i,
  input  logic                  halt_req_i,
  input  logic                  stop_req_i,
  input  logic                  irq_i,
  input  logic                  opt_rc_i,
  input  logic                  opt_keep_i,
  input  logic [STAB_SEL_W-1:0] stab_sel_i,
  input  logic                  wdt_clr_i,
  output logic [1:0]            status_o,
  output logic                  mcs_o,
  output logic                  hs_run_o,
  output logic                  int_run_o,
  output logic                  cpu_clk_en_o,
  output logic                  halt_o,
  output logic                  stop_o,
  output logic                  stab_done_o,
  output logic                  err_o,
  output logic                  wdt_rst_o
);
  ck_stat_e st;
  pwr_e     pwr;
  logic     err, stab_done, stab_ok, wdt_ovf, soft_rst, hs_run, int_run;
  logic     wdt_rst_q;

  assign soft_rst = por_i || lvd_i || clkmon_i || wdt_ovf;
  assign hs_run   = (st != ST_1) && (pwr != PW_STOP);
  assign int_run  = (pwr != PW_STOP) || opt_keep_i;
  assign stab_ok  = stab_done || opt_rc_i;

  ckm_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .wr_i       (reg_wr_i),
    .wr_stop_i  (reg_stop_i),
    .wr_sel_i   (reg_sel_i),
    .halt_req_i (halt_req_i),
    .stop_req_i (stop_req_i),
    .irq_i      (irq_i),
    .stab_ok_i  (stab_ok),
    .st_o       (st),
    .pwr_o      (pwr),
    .err_o      (err)
  );

  ckm_stab_cnt #(
    .MIN_EXP (STAB_MIN_EXP),
    .MAX_EXP (STAB_MAX_EXP),
    .SEL_W   (STAB_SEL_W)
  ) u_stab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (soft_rst),
    .run_i  (hs_run),
    .sel_i  (stab_sel_i),
    .done_o (stab_done)
  );

  ckm_wdt #(
    .W (WDT_W)
  ) u_wdt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (soft_rst),
    .kick_i (wdt_clr_i),
    .run_i  (int_run),
    .ovf_o  (wdt_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wdt_rst_q <= 1'b0;
    else         wdt_rst_q <= wdt_ovf;
  end

  assign status_o     = st;
  assign mcs_o        = (st == ST_3);
  assign hs_run_o     = hs_run;
  assign int_run_o    = int_run;
  // CPU held on a cold high-speed source after STOP release
  assign cpu_clk_en_o = (pwr == PW_RUN) && ((st != ST_3) || stab_ok);
  assign halt_o       = (pwr == PW_HALT);
  assign stop_o       = (pwr == PW_STOP);
  assign stab_done_o  = stab_done;
  assign err_o        = err;
  assign wdt_rst_o    = wdt_rst_q;
endmodule

// File: rtl/ckm_chk.sv
`timescale 1ns/1ps
module ckm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_i,
  input logic       lvd_i,
  input logic       clkmon_i,
  input logic       opt_rc_i,
  input logic       opt_keep_i,
  input logic [1:0] status_o,
  input logic       mcs_o,
  input logic       hs_run_o,
  input logic       int_run_o,
  input logic       cpu_clk_en_o,
  input logic       halt_o,
  input logic       stop_o,
  input logic       stab_done_o,
  input logic       err_o,
  input logic       wdt_rst_o
);
  // R1
  rst_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i || lvd_i || clkmon_i) |=> (status_o == 2'd1) && !err_o && !halt_o && !stop_o);

  // R4
  mcs_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mcs_o) |-> $past(stab_done_o || opt_rc_i));

  // R3
  stab_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_run_o |=> !stab_done_o);

  // R3
  stab_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stab_done_o) |-> $past(hs_run_o));

  // R5
  hs_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_run_o) |-> (status_o == 2'd1) || stop_o);

  // R6
  st3_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd3) |=> (status_o != 2'd1) || wdt_rst_o || $past(por_i || lvd_i || clkmon_i));

  // R7
  park_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o || stop_o) |-> !cpu_clk_en_o);

  // R8
  stop_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !opt_keep_i) |-> !int_run_o);

  // R9
  wdt_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> (status_o == 2'd1) && !err_o && !stop_o && !halt_o);

  // R9
  wdt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);

  // R10
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> $past(por_i || lvd_i || clkmon_i) || wdt_rst_o);
endmodule

bind clk_mode_ctrl ckm_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .por_i        (por_i),
  .lvd_i        (lvd_i),
  .clkmon_i     (clkmon_i),
  .opt_rc_i     (opt_rc_i),
  .opt_keep_i   (opt_keep_i),
  .status_o     (status_o),
  .mcs_o        (mcs_o),
  .hs_run_o     (hs_run_o),
  .int_run_o    (int_run_o),
  .cpu_clk_en_o (cpu_clk_en_o),
  .halt_o       (halt_o),
  .stop_o       (stop_o),
  .stab_done_o  (stab_done_o),
  .err_o        (err_o),
  .wdt_rst_o    (wdt_rst_o)
);

// File: tb/sim_clk_mode_ctrl.sv
`timescale 1ns/1ps
module sim_clk_mode_ctrl;
  localparam int WW   = 8;
  localparam int WMAX = (1 << WW) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_ni = 1'b0;
  logic       por_i = 0, lvd_i = 0, clkmon_i = 0;
  logic       reg_wr_i = 0, reg_stop_i = 0, reg_sel_i = 0;
  logic       halt_req_i = 0, stop_req_i = 0, irq_i = 0;
  logic       opt_rc_i = 0, opt_keep_i = 0;
  logic [2:0] stab_sel_i = 3'd0;
  logic       wdt_clr_i = 0;
  logic [1:0] status_o;
  logic       mcs_o, hs_run_o, int_run_o, cpu_clk_en_o, halt_o, stop_o;
  logic       stab_done_o, err_o, wdt_rst_o;

  clk_mode_ctrl #(.WDT_W(WW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .por_i(por_i), .lvd_i(lvd_i), .clkmon_i(clkmon_i),
    .reg_wr_i(reg_wr_i), .reg_stop_i(reg_stop_i), .reg_sel_i(reg_sel_i),
    .halt_req_i(halt_req_i), .stop_req_i(stop_req_i), .irq_i(irq_i),
    .opt_rc_i(opt_rc_i), .opt_keep_i(opt_keep_i), .stab_sel_i(stab_sel_i),
    .wdt_clr_i(wdt_clr_i), .status_o(status_o), .mcs_o(mcs_o), .hs_run_o(hs_run_o),
    .int_run_o(int_run_o), .cpu_clk_en_o(cpu_clk_en_o), .halt_o(halt_o),
    .stop_o(stop_o), .stab_done_o(stab_done_o), .err_o(err_o), .wdt_rst_o(wdt_rst_o)
  );

  int  n_chk = 0, n_fail = 0;
  bit  fin = 0;
  bit  seen_wrst = 0;

  // watchdog clear driver
  bit  kick_en = 1, man_kick = 0;
  int  kc = 0;
  always @(posedge clk) begin
    #2;
    kc++;
    wdt_clr_i = kick_en ? (kc % 64 == 0) : man_kick;
  end

  // behavioural reference: status 1..3, power 0 run / 1 halt / 2 stop
  int m_st = 1, m_pw = 0, m_err = 0, m_sc = 0, m_sd = 0, m_wc = 0, m_wr = 0;
  int ir, ovf, hs, ok, nst, npw, nerr;

  function automatic int lim(int sel);
    return 1 << ((sel > 5) ? 16 : 11 + sel);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 1; m_pw = 0; m_err = 0; m_sc = 0; m_sd = 0; m_wc = 0; m_wr = 0;
    end else begin
      ir  = (m_pw != 2 || opt_keep_i) ? 1 : 0;
      ovf = (ir == 1 && m_wc == WMAX && !wdt_clr_i) ? 1 : 0;
      if (por_i || lvd_i || clkmon_i || ovf == 1) begin
        m_st = 1; m_pw = 0; m_err = 0; m_sc = 0; m_sd = 0; m_wc = 0;
      end else begin
        hs = (m_st != 1 && m_pw != 2) ? 1 : 0;
        ok = (m_sd == 1 || opt_rc_i) ? 1 : 0;
        nst = m_st; npw = m_pw; nerr = m_err;
        if (m_pw == 0) begin
          if (reg_wr_i) begin
            if (reg_sel_i && reg_stop_i) nerr = 1;
            else if (reg_sel_i) begin
              if (m_st == 2 && ok == 1) nst = 3;
              else if (m_st != 3) nerr = 1;
            end else if (reg_stop_i) begin
              if (m_st == 2) nst = 1;
              else if (m_st == 3) nerr = 1;
            end else if (m_st != 2) nst = 2;
          end
          if (stop_req_i) npw = 2;
          else if (halt_req_i) npw = 1;
        end else if (irq_i) npw = 0;
        if (hs == 0) begin m_sc = 0; m_sd = 0; end
        else if (m_sd == 0) begin
          m_sc++;
          if (m_sc >= lim(int'(stab_sel_i))) m_sd = 1;
        end
        if (wdt_clr_i) m_wc = 0;
        else if (ir == 1) m_wc = (m_wc + 1) % (WMAX + 1);
        m_st = nst; m_pw = npw; m_err = nerr;
      end
      m_wr = ovf;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !fin) begin
      chk("R2 status_o", int'(status_o), m_st);
      chk("R4 mcs_o", int'(mcs_o), (m_st == 3) ? 1 : 0);
      chk("R8 hs_run_o", int'(hs_run_o), (m_st != 1 && m_pw != 2) ? 1 : 0);
      chk("R8 int_run_o", int'(int_run_o), (m_pw != 2 || opt_keep_i) ? 1 : 0);
      chk("R7 cpu_clk_en_o", int'(cpu_clk_en_o),
          (m_pw == 0 && (m_st != 3 || m_sd == 1 || opt_rc_i)) ? 1 : 0);
      chk("R7 halt_o", int'(halt_o), (m_pw == 1) ? 1 : 0);
      chk("R8 stop_o", int'(stop_o), (m_pw == 2) ? 1 : 0);
      chk("R3 stab_done_o", int'(stab_done_o), m_sd);
      chk("R10 err_o", int'(err_o), m_err);
      chk("R9 wdt_rst_o", int'(wdt_rst_o), m_wr);
      if (wdt_rst_o) seen_wrst = 1;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic idle(input int n);
    repeat (n) step();
  endtask
  task automatic wr(input bit s, input bit c);
    reg_wr_i = 1; reg_stop_i = s; reg_sel_i = c;
    step();
    reg_wr_i = 0; reg_stop_i = 0; reg_sel_i = 0;
  endtask
  task automatic p_halt();  halt_req_i = 1; step(); halt_req_i = 0; endtask
  task automatic p_stop();  stop_req_i = 1; step(); stop_req_i = 0; endtask
  task automatic p_irq();   irq_i = 1;      step(); irq_i = 0;      endtask
  task automatic p_kick();  man_kick = 1;   step(); man_kick = 0;   endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    step();
    // R1 reset state
    chk("R1 status after reset", int'(status_o), 1);
    chk("R1 hs_run after reset", int'(hs_run_o), 0);
    chk("R1 err after reset", int'(err_o), 0);
    // R2
    wr(0, 0);
    chk("R2 status 1->2", int'(status_o), 2);
    chk("R2 hs_run on", int'(hs_run_o), 1);
    // R4 early select refused
    wr(0, 1);
    chk("R4 early select status", int'(status_o), 2);
    chk("R4 early select err", int'(err_o), 1);
    // R3 stabilization edge
    idle(2040);
    chk("R3 not yet done", int'(stab_done_o), 0);
    idle(7);
    chk("R3 done at 2^11", int'(stab_done_o), 1);
    // R4 legal select
    wr(0, 1);
    chk("R4 status 2->3", int'(status_o), 3);
    chk("R4 mcs set", int'(mcs_o), 1);
    chk("R10 err sticky", int'(err_o), 1);
    // R5 stop while on high-speed refused
    wr(1, 1);
    chk("R5 stop refused in 3", int'(status_o), 3);
    // R7 halt
    p_halt();
    chk("R7 halted", int'(halt_o), 1);
    chk("R7 cpu gated", int'(cpu_clk_en_o), 0);
    wr(0, 0);
    chk("R10 write in halt ignored", int'(status_o), 3);
    p_irq();
    chk("R7 resume status", int'(status_o), 3);
    chk("R7 resume run", int'(halt_o), 0);
    // R8 stop, internal oscillator may stop
    p_stop();
    chk("R8 stopped", int'(stop_o), 1);
    chk("R8 hs off", int'(hs_run_o), 0);
    chk("R8 int off", int'(int_run_o), 0);
    idle(50);
    p_irq();
    chk("R8 release status", int'(status_o), 3);
    chk("R8 cpu waits", int'(cpu_clk_en_o), 0);
    idle(2048);
    chk("R8 cpu restarts", int'(cpu_clk_en_o), 1);
    // R8 STOP wins over HALT
    halt_req_i = 1; stop_req_i = 1; step(); halt_req_i = 0; stop_req_i = 0;
    chk("R8 stop priority", int'(stop_o), 1);
    p_irq();
    idle(2048);
    // R6 and R5
    wr(0, 0);
    chk("R6 status 3->2", int'(status_o), 2);
    wr(1, 0);
    chk("R5 status 2->1", int'(status_o), 1);
    chk("R5 hs stopped", int'(hs_run_o), 0);
    // R1 power-on clear
    por_i = 1; step(); por_i = 0;
    chk("R1 por clears err", int'(err_o), 0);
    // R4 RC option bypass
    opt_rc_i = 1;
    wr(0, 0);
    wr(0, 1);
    chk("R4 rc switch", int'(status_o), 3);
    chk("R4 rc no err", int'(err_o), 0);
    wr(0, 0);
    wr(1, 0);
    opt_rc_i = 0;
    // R3 clamped exponent
    stab_sel_i = 3'd7;
    wr(0, 0);
    idle(65535);
    chk("R3 clamp not done", int'(stab_done_o), 0);
    idle(1);
    chk("R3 clamp done at 2^16", int'(stab_done_o), 1);
    stab_sel_i = 3'd1;
    wr(1, 0);
    wr(0, 0);
    idle(4200);
    wr(1, 0);
    stab_sel_i = 3'd0;
    // R9 frozen in STOP, then overflow
    wr(0, 0);
    kick_en = 0;
    p_kick();
    p_stop();
    idle(600);
    chk("R9 frozen no reset", int'(seen_wrst), 0);
    chk("R9 still stopped", int'(stop_o), 1);
    p_irq();
    idle(300);
    chk("R9 overflow reset seen", int'(seen_wrst), 1);
    chk("R9 status after wdt", int'(status_o), 1);
    // R11 overflow with STOP release in same cycle
    opt_keep_i = 1;
    wr(0, 0);
    p_kick();
    p_stop();
    for (int i = 0; i < 1000 && m_wc != WMAX; i++) step();
    irq_i = 1; step(); irq_i = 0;
    chk("R11 status reset", int'(status_o), 1);
    chk("R11 run mode", int'(stop_o), 0);
    chk("R11 wdt pulse", int'(wdt_rst_o), 1);
    opt_keep_i = 0;
    kick_en = 1;
    // R1 other sources
    wr(0, 0);
    wr(0, 1);
    lvd_i = 1; step(); lvd_i = 0;
    chk("R1 lvd status", int'(status_o), 1);
    chk("R1 lvd err", int'(err_o), 0);
    wr(0, 0);
    wr(0, 1);
    clkmon_i = 1; step(); clkmon_i = 0;
    chk("R1 clkmon status", int'(status_o), 1);
    chk("R1 clkmon err", int'(err_o), 0);
    idle(4);
    fin = 1;
    summary();
    $finish;
  end
endmodule